// File: doc/BRIEF.md
# Timer Compare-Match Output Unit

This block keeps the output-compare state bit of one timer channel and places it on a general-purpose I/O pin that is shared with port logic. The timer signals a compare match with a one-cycle pulse. A stored 2-bit output-mode field then decides whether the state bit toggles, clears, sets or stays as it is. A force strobe applies the same action with no match, so the state bit can be given its first value before the pin is turned into an output. The force strobe only acts while the waveform mode is normal.

Whenever the stored mode field is not zero, the pin's output value comes from the state bit and the port data bit is not used. The pin's output enable always comes from the data-direction bit, and the override has no effect on it. The mode field and the direction bit are taken into registers on every clock with no double buffering, so a new value applies from the next clock on. The state bit has a register of its own, and a change of waveform mode does not alter it.

Top module: `cmp_out_unit`

## Requirements
- R1: A synchronous active-high reset clears the state bit, the stored mode field and the stored direction bit to 0. After reset the pin output equals the port data bit and the output enable is 0.
- R2: With stored mode 01, every compare-match pulse inverts the state bit.
- R3: With stored mode 10, a compare match clears the state bit to 0. With stored mode 11, a compare match sets it to 1.
- R4: With stored mode 00, a compare match leaves the state bit unchanged.
- R5: When the stored mode is not 00, the pin output equals the state bit. When the stored mode is 00, the pin output equals the port data bit. A new mode value applies from the clock edge after it is presented.
- R6: The output enable equals the direction input registered one clock earlier, whatever the mode. While the output enable is 0, the read-back bit equals the external pad level. While it is 1, the read-back bit equals the pin output.
- R7: While the PWM-mode input is 0, a force strobe updates the state bit with the action of the stored mode, in the same way as a compare match.
- R8: While the PWM-mode input is 1, a force strobe has no effect on the state bit.
- R9: When a compare match and a force strobe arrive in the same cycle, the mode action is applied once. With mode 01 this means a single inversion.
- R10: A change of the PWM-mode input does not change the state bit.
- R11: The choice between state bit and port data does not depend on the PWM-mode input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_match_i | input | 1 | Compare-match pulse from the timer |
| out_mode_i | input | 2 | Output-mode field: 00 off, 01 toggle, 10 clear, 11 set |
| force_i | input | 1 | Force-compare strobe |
| pwm_mode_i | input | 1 | 1 while the timer runs in a PWM waveform mode |
| port_data_i | input | 1 | Port data bit from the GPIO register |
| port_dir_i | input | 1 | Data-direction bit, 1 = output |
| pad_i | input | 1 | External level present at the pin |
| pin_out_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Pin driver enable; the driver is tri-stated when 0 |
| pin_rd_o | output | 1 | Level read back from the pin |

## Verification
The state bit is taken through every mode action: toggle twice in a row, clear from 1, set from 0, and hold under mode 00. Each action is brought out on the pin by choosing a nonzero mode, which tells a real update apart from a bit that merely kept its value. A force is tried in normal mode and in PWM mode, which shows whether the PWM input gates it. A match and a force in the same cycle under toggle show whether the action is applied once or twice. Changes of direction and of PWM mode are made while the override is active, to show that the output enable and the state bit do not depend on the override or on the waveform mode.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;
   typedef enum logic [1:0] {
      OCM_OFF    = 2'b00,
      OCM_TOGGLE = 2'b01,
      OCM_CLEAR  = 2'b10,
      OCM_SET    = 2'b11
   } ocm_e;

   function automatic logic ocm_apply(input ocm_e mode, input logic cur);
      case (mode)
         OCM_TOGGLE: ocm_apply = ~cur;
         OCM_CLEAR:  ocm_apply = 1'b0;
         OCM_SET:    ocm_apply = 1'b1;
         default:    ocm_apply = cur;
      endcase
   endfunction
endpackage

// File: rtl/cmp_out_ctrl_reg.sv
module cmp_out_ctrl_reg
   import cmp_out_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              dir_i,
   output ocm_e              mode_q,
   output logic              dir_q
);
   initial begin
      if (MODE_W != 2) $error("cmp_out_ctrl_reg: MODE_W must be 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= OCM_OFF;
         dir_q  <= 1'b0;
      end else begin
         mode_q <= ocm_e'(mode_i);
         dir_q  <= dir_i;
      end
   end
endmodule

// File: rtl/cmp_out_state.sv
module cmp_out_state
   import cmp_out_pkg::*;
#(
   parameter bit OC_RST = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic match_i,
   input  logic force_i,
   input  logic pwm_i,
   input  ocm_e mode_i,
   output logic oc_q
);
   logic evt;

   // a match and a force in one cycle merge into a single event
   assign evt = match_i | (force_i & ~pwm_i);

   always_ff @(posedge clk) begin
      if (rst)
         oc_q <= OC_RST;
      else if (evt)
         oc_q <= ocm_apply(mode_i, oc_q);
   end
endmodule

// File: rtl/cmp_out_pin.sv
module cmp_out_pin
   import cmp_out_pkg::*;
#(
   parameter bit REG_PIN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  ocm_e mode_i,
   input  logic oc_i,
   input  logic port_data_i,
   input  logic dir_i,
   input  logic pad_i,
   output logic pin_out_o,
   output logic pin_oe_o,
   output logic pin_rd_o
);
   logic sel_oc;
   logic mux_out;

   assign sel_oc  = (mode_i != OCM_OFF);
   assign mux_out = sel_oc ? oc_i : port_data_i;

   generate
      if (REG_PIN) begin : g_reg
         logic out_q;
         always_ff @(posedge clk) begin
            if (rst) out_q <= 1'b0;
            else     out_q <= mux_out;
         end
         assign pin_out_o = out_q;
      end else begin : g_comb
         assign pin_out_o = mux_out;
      end
   endgenerate

   assign pin_oe_o = dir_i;
   assign pin_rd_o = dir_i ? pin_out_o : pad_i;
endmodule

// File: rtl/cmp_out_unit.sv
module cmp_out_unit
   import cmp_out_pkg::*;
#(
   parameter int MODE_W  = 2,
   parameter bit OC_RST  = 1'b0,
   parameter bit REG_PIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmp_match_i,
   input  logic [MODE_W-1:0] out_mode_i,
   input  logic              force_i,
   input  logic              pwm_mode_i,
   input  logic              port_data_i,
   input  logic              port_dir_i,
   input  logic              pad_i,
   output logic              pin_out_o,
   output logic              pin_oe_o,
   output logic              pin_rd_o
);
   ocm_e mode_q;
   logic dir_q;
   logic oc_q;

   cmp_out_ctrl_reg #(.MODE_W(MODE_W)) u_ctrl (
      .clk(clk), .rst(rst), .mode_i(out_mode_i), .dir_i(port_dir_i),
      .mode_q(mode_q), .dir_q(dir_q)
   );

   cmp_out_state #(.OC_RST(OC_RST)) u_state (
      .clk(clk), .rst(rst), .match_i(cmp_match_i), .force_i(force_i),
      .pwm_i(pwm_mode_i), .mode_i(mode_q), .oc_q(oc_q)
   );

   cmp_out_pin #(.REG_PIN(REG_PIN)) u_pin (
      .clk(clk), .rst(rst), .mode_i(mode_q), .oc_i(oc_q),
      .port_data_i(port_data_i), .dir_i(dir_q), .pad_i(pad_i),
      .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_rd_o(pin_rd_o)
   );
endmodule

// File: rtl/cmp_out_unit_chk.sv
module cmp_out_unit_chk (
   input logic       clk,
   input logic       rst,
   input logic       cmp_match_i,
   input logic       force_i,
   input logic       pwm_mode_i,
   input logic       port_dir_i,
   input logic       pad_i,
   input logic [1:0] mode_q,
   input logic       oc_q,
   input logic       pin_oe_o,
   input logic       pin_rd_o
);
   AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> pin_oe_o == $past(port_dir_i)); // R6
   AST_RD_FROM_PAD: assert property (@(posedge clk) disable iff (rst)
      !pin_oe_o |-> pin_rd_o == pad_i); // R6
   AST_TOGGLE: assert property (@(posedge clk) disable iff (rst)
      (cmp_match_i && mode_q == 2'b01) |=> oc_q != $past(oc_q)); // R2
   AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (cmp_match_i && mode_q == 2'b10) |=> !oc_q); // R3
   AST_SET: assert property (@(posedge clk) disable iff (rst)
      (cmp_match_i && mode_q == 2'b11) |=> oc_q); // R3
   AST_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
      (mode_q == 2'b00) |=> $stable(oc_q)); // R4
   AST_PWM_NO_FORCE: assert property (@(posedge clk) disable iff (rst)
      (force_i && pwm_mode_i && !cmp_match_i) |=> $stable(oc_q)); // R8
endmodule

bind cmp_out_unit cmp_out_unit_chk u_chk (
   .clk(clk), .rst(rst), .cmp_match_i(cmp_match_i), .force_i(force_i),
   .pwm_mode_i(pwm_mode_i), .port_dir_i(port_dir_i), .pad_i(pad_i),
   .mode_q(mode_q), .oc_q(oc_q), .pin_oe_o(pin_oe_o), .pin_rd_o(pin_rd_o)
);

// File: tb/cmp_out_unit_tb.sv
module cmp_out_unit_tb;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic cmp_match_i = 1'b0;
   logic [1:0] out_mode_i = 2'b00;
   logic force_i = 1'b0;
   logic pwm_mode_i = 1'b0;
   logic port_data_i = 1'b1;
   logic port_dir_i = 1'b0;
   logic pad_i = 1'b1;
   logic pin_out_o, pin_oe_o, pin_rd_o;
   int n_run = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   cmp_out_unit u_dut (
      .clk(clk), .rst(rst), .cmp_match_i(cmp_match_i), .out_mode_i(out_mode_i),
      .force_i(force_i), .pwm_mode_i(pwm_mode_i), .port_data_i(port_data_i),
      .port_dir_i(port_dir_i), .pad_i(pad_i), .pin_out_o(pin_out_o),
      .pin_oe_o(pin_oe_o), .pin_rd_o(pin_rd_o)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic pulse_match();
      cmp_match_i = 1'b1; tick(); cmp_match_i = 1'b0;
   endtask

   task automatic t_reset();
      rst = 1'b1; tick(); tick(); rst = 1'b0;
      chk("R1 pin_out", pin_out_o, 1'b1);
      chk("R1 pin_oe", pin_oe_o, 1'b0);
      chk("R6 rd pad", pin_rd_o, 1'b1);
   endtask

   task automatic t_force_init();
      out_mode_i = 2'b11; tick();
      chk("R1/R5 oc zero on pin", pin_out_o, 1'b0);
      force_i = 1'b1; tick(); force_i = 1'b0;
      chk("R7 force sets", pin_out_o, 1'b1);
      pad_i = 1'b0; #1;
      chk("R6 oe off", pin_oe_o, 1'b0);
      chk("R6 rd pad", pin_rd_o, 1'b0);
   endtask

   task automatic t_dir();
      port_dir_i = 1'b1; #1;
      chk("R6 oe delayed", pin_oe_o, 1'b0);
      tick();
      chk("R6 oe on", pin_oe_o, 1'b1);
      chk("R6 rd pin", pin_rd_o, 1'b1);
   endtask

   task automatic t_clear_set();
      out_mode_i = 2'b10; tick();
      chk("R3 no match hold", pin_out_o, 1'b1);
      pulse_match();
      chk("R3 clear", pin_out_o, 1'b0);
      out_mode_i = 2'b11; tick();
      pulse_match();
      chk("R3 set", pin_out_o, 1'b1);
   endtask

   task automatic t_toggle();
      out_mode_i = 2'b01; tick();
      pulse_match();
      chk("R2 toggle 1", pin_out_o, 1'b0);
      pulse_match();
      chk("R2 toggle 2", pin_out_o, 1'b1);
   endtask

   task automatic t_off();
      out_mode_i = 2'b00; port_data_i = 1'b0; #1;
      chk("R5 mode change delayed", pin_out_o, 1'b1);
      tick();
      chk("R5 port data", pin_out_o, 1'b0);
      port_data_i = 1'b1; #1;
      chk("R5 port data 1", pin_out_o, 1'b1);
      port_data_i = 1'b0;
      pulse_match();
      out_mode_i = 2'b10; tick();
      chk("R4 hold under off", pin_out_o, 1'b1);
   endtask

   task automatic t_pwm();
      pwm_mode_i = 1'b1; out_mode_i = 2'b01; tick();
      chk("R10 oc kept", pin_out_o, 1'b1);
      chk("R11 override in pwm", pin_out_o, 1'b1);
      force_i = 1'b1; tick(); force_i = 1'b0;
      chk("R8 force ignored", pin_out_o, 1'b1);
      pwm_mode_i = 1'b0; tick();
      chk("R10 oc kept back", pin_out_o, 1'b1);
   endtask

   task automatic t_both();
      cmp_match_i = 1'b1; force_i = 1'b1; tick();
      cmp_match_i = 1'b0; force_i = 1'b0;
      chk("R9 single toggle", pin_out_o, 1'b0);
   endtask

   initial begin
      #20000;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1;
      t_reset();
      t_force_init();
      t_dir();
      t_clear_set();
      t_toggle();
      t_off();
      t_pwm();
      t_both();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule